// File: doc/BRIEF.md
# Bus Target Read Responder

This block is the target side of a 32-bit synchronous, multiplexed address/data bus. It serves read bursts from a bank of read-only words that the surrounding logic supplies. An address phase starts a transaction when the frame strobe falls after the bus has been idle. The block checks the command and the address, claims the transaction with its device-select strobe, waits one turnaround cycle, and then returns one word per completed data phase. A data phase completes on every clock edge where both the initiator-ready and target-ready strobes are low.

The block is always ready once it is in its data phases, so the initiator sets the pace by inserting wait states. The word address advances after each completed phase and wraps inside the 64-byte window. The phase in which the initiator raises the frame strobe while it is ready is the final one. After that phase the block releases all of its strobes and stops driving the data lines.

Top module: `pci_rd_target`

## Requirements
- R1: While reset is held and after its release, with no transaction, devsel_no and trdy_no are 1 and ad_oe_o is 0.
- R2: An address phase is the first rising edge with frame_ni=0 after an edge with frame_ni=1. It is claimed when all of these hold: cbe_ni=4'b0110 (memory read), ad_i[1:0]=2'b00, and ad_i[31:6] equals the base address bits [31:6] (default base 32'h0000_1000). devsel_no is then 0 in the cycle after that edge.
- R3: An address phase with any other command, a nonzero ad_i[1:0], or an address outside the window is not claimed. devsel_no and trdy_no stay 1 and ad_oe_o stays 0 until frame_ni returns to 1.
- R4: In the first cycle of a claimed transaction (turnaround), trdy_no is 1 and ad_oe_o is 0. From the next cycle on, trdy_no is 0 and ad_oe_o is 1.
- R5: The first data phase returns word k = ad_i[5:2] of the address phase, where word k is bank_i[32*k+31 : 32*k].
- R6: A data phase completes on an edge with irdy_ni=0 and trdy_no=0, and the word index then advances by one. A cycle with irdy_ni=1 is a wait state: the same word is held.
- R7: The word index wraps from 15 to 0.
- R8: Byte lane b of ad_o (bits 8b+7:8b) carries byte b of the word when cbe_ni[b]=0, and is 0 when cbe_ni[b]=1.
- R9: After a completed phase with frame_ni=1, devsel_no and trdy_no are 1 and ad_oe_o is 0 in the next cycle. An address phase in the cycle after that is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_ni | input | 1 | Transaction frame strobe from the initiator, active low |
| irdy_ni | input | 1 | Initiator ready, active low |
| ad_i | input | 32 | Multiplexed address/data lines as seen by the target |
| cbe_ni | input | 4 | Command during the address phase, byte enables (active low) during data phases |
| bank_i | input | 512 | Sixteen 32-bit read words, word k at bits 32k+31:32k |
| devsel_no | output | 1 | Device select, active low |
| trdy_no | output | 1 | Target ready, active low |
| ad_o | output | 32 | Read data for the address/data lines |
| ad_oe_o | output | 1 | Drive enable for ad_o |

## Verification
The bench inserts a wait state in the middle of a burst. A design that advanced on target-ready alone would return the next word one phase early. A burst starting at word 14 crosses the window end and must read words 0 and 1 next; a carry into the base bits would miss that. Rejected address phases use the I/O-read code, an address just past the window, and a misaligned address; a decoder that ignored any field would claim one of them. Bursts run back to back with a single idle cycle between them, and one burst uses sparse byte enables. These cases catch a target that holds device-select too long, skips the turnaround, or drives disabled byte lanes.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TURN = 2'd1,
    ST_DATA = 2'd2
  } tgt_state_e;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [1:0] BURST_LINEAR = 2'b00;
endpackage

// File: rtl/pci_tgt_decode.sv
module pci_tgt_decode
  import pci_tgt_pkg::*;
#(
  parameter int          AW        = 32,
  parameter int          BEW       = 4,
  parameter int          WIN_BYTES = 64,
  parameter logic [31:0] BASE_ADDR = 32'h0000_1000,
  localparam int         OFS_W     = $clog2(WIN_BYTES),
  localparam int         BYTE_W    = $clog2(BEW),
  localparam int         IDX_W     = OFS_W - BYTE_W
) (
  input  logic [AW-1:0]    ad_i,
  input  logic [BEW-1:0]   cmd_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  logic cmd_ok, base_ok, align_ok;

  assign cmd_ok   = (cmd_i == BEW'(CMD_MEM_RD));
  assign base_ok  = (ad_i[AW-1:OFS_W] == BASE_ADDR[AW-1:OFS_W]);
  assign align_ok = (ad_i[BYTE_W-1:0] == BYTE_W'(BURST_LINEAR));
  assign hit_o    = cmd_ok && base_ok && align_ok;
  assign idx_o    = ad_i[OFS_W-1:BYTE_W];
endmodule

// File: rtl/pci_tgt_fsm.sv
module pci_tgt_fsm
  import pci_tgt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_ni,
  input  logic irdy_ni,
  input  logic hit_i,
  output logic start_o,
  output logic load_o,
  output logic xfer_o,
  output logic devsel_no,
  output logic trdy_no,
  output logic oe_o
);
  tgt_state_e state_q, state_d;
  logic       frame_q;

  // address phase: first low frame after an idle edge
  assign start_o = (state_q == ST_IDLE) && !frame_ni && frame_q;
  assign load_o  = start_o && hit_i;
  assign xfer_o  = (state_q == ST_DATA) && !irdy_ni;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (load_o) state_d = ST_TURN;
      ST_TURN: state_d = ST_DATA;
      ST_DATA: if (xfer_o && frame_ni) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      frame_q <= 1'b1;
    end else begin
      state_q <= state_d;
      frame_q <= frame_ni;
    end
  end

  assign devsel_no = (state_q == ST_IDLE);
  assign trdy_no   = (state_q != ST_DATA);
  assign oe_o      = (state_q == ST_DATA);

  // R4: turnaround is followed by the first data cycle
  p_turn_to_data_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(devsel_no) |=> !trdy_no && oe_o);

  // R6: a wait state keeps the target in its data phases
  p_wait_holds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trdy_no && irdy_ni) |=> !trdy_no && !devsel_no);

  // R9: final phase releases every strobe
  p_final_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trdy_no && !irdy_ni && frame_ni) |=> devsel_no && trdy_no && !oe_o);
endmodule

// File: rtl/pci_tgt_rdata.sv
module pci_tgt_rdata #(
  parameter int  DW    = 32,
  parameter int  WORDS = 16,
  localparam int BEW   = DW / 8,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [IDX_W-1:0]    start_idx_i,
  input  logic                xfer_i,
  input  logic                oe_i,
  input  logic [BEW-1:0]      be_ni,
  input  logic [WORDS*DW-1:0] bank_i,
  output logic [DW-1:0]       ad_o
);
  logic [IDX_W-1:0] idx_q;
  logic [DW-1:0]    word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (load_i) idx_q <= start_idx_i;
    else if (xfer_i) idx_q <= idx_q + 1'b1; // wraps inside the window
  end

  assign word = bank_i[int'(idx_q)*DW +: DW];

  for (genvar b = 0; b < BEW; b++) begin : g_lane
    assign ad_o[b*8 +: 8] = (oe_i && !be_ni[b]) ? word[b*8 +: 8] : 8'h00;
  end

  // R6: the index only moves on load or completed phase
  p_hold_idx_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !xfer_i) |=> $stable(idx_q));

  // R7: wrap from the last word to word 0
  p_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i && !load_i && (&idx_q)) |=> (idx_q == '0));
endmodule

// File: rtl/pci_rd_target.sv
module pci_rd_target
  import pci_tgt_pkg::*;
#(
  parameter int          DW        = 32,
  parameter int          WIN_BYTES = 64,
  parameter logic [31:0] BASE_ADDR = 32'h0000_1000,
  localparam int         BEW       = DW / 8,
  localparam int         WORDS     = WIN_BYTES / BEW,
  localparam int         IDX_W     = $clog2(WORDS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                frame_ni,
  input  logic                irdy_ni,
  input  logic [DW-1:0]       ad_i,
  input  logic [BEW-1:0]      cbe_ni,
  input  logic [WORDS*DW-1:0] bank_i,
  output logic                devsel_no,
  output logic                trdy_no,
  output logic [DW-1:0]       ad_o,
  output logic                ad_oe_o
);
  logic             hit, start, load, xfer, oe;
  logic [IDX_W-1:0] start_idx;

  pci_tgt_decode #(
    .AW(DW), .BEW(BEW), .WIN_BYTES(WIN_BYTES), .BASE_ADDR(BASE_ADDR)
  ) i_decode (
    .ad_i  (ad_i),
    .cmd_i (cbe_ni),
    .hit_o (hit),
    .idx_o (start_idx)
  );

  pci_tgt_fsm i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .frame_ni  (frame_ni),
    .irdy_ni   (irdy_ni),
    .hit_i     (hit),
    .start_o   (start),
    .load_o    (load),
    .xfer_o    (xfer),
    .devsel_no (devsel_no),
    .trdy_no   (trdy_no),
    .oe_o      (oe)
  );

  pci_tgt_rdata #(.DW(DW), .WORDS(WORDS)) i_rdata (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .start_idx_i (start_idx),
    .xfer_i      (xfer),
    .oe_i        (oe),
    .be_ni       (cbe_ni),
    .bank_i      (bank_i),
    .ad_o        (ad_o)
  );

  assign ad_oe_o = oe;

  // R3: a rejected address phase leaves the bus unclaimed
  p_miss_no_claim_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && !hit) |=> devsel_no && trdy_no);
endmodule

// File: tb/test_pci_rd_target.sv
`timescale 1ns/1ps
module test_pci_rd_target;
  localparam int          DW    = 32;
  localparam int          WORDS = 16;
  localparam logic [31:0] BASE  = 32'h0000_1000;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                frame_n = 1'b1;
  logic                irdy_n = 1'b1;
  logic [DW-1:0]       ad = '0;
  logic [3:0]          cbe_n = 4'hF;
  logic [WORDS*DW-1:0] bank;
  logic                devsel_n, trdy_n, ad_oe;
  logic [DW-1:0]       ad_out;

  int    checks = 0;
  int    failures = 0;
  string cur_req = "R5";
  logic [DW-1:0] exp_q[$];

  always #2.5 clk = ~clk;

  pci_rd_target i_pci_rd_target (
    .clk_i(clk), .rst_ni(rst_n), .frame_ni(frame_n), .irdy_ni(irdy_n),
    .ad_i(ad), .cbe_ni(cbe_n), .bank_i(bank),
    .devsel_no(devsel_n), .trdy_no(trdy_n), .ad_o(ad_out), .ad_oe_o(ad_oe)
  );

  function automatic logic [31:0] bank_word(int w);
    return {8'(w), 8'hC3 ^ 8'(w * 7), 8'(w * 13 + 1), 8'h5A};
  endfunction

  function automatic logic [31:0] lane_mask(logic [3:0] be_n);
    logic [31:0] m = '0;
    for (int b = 0; b < 4; b++) if (!be_n[b]) m[b*8 +: 8] = 8'hFF;
    return m;
  endfunction

  initial for (int w = 0; w < WORDS; w++) bank[w*DW +: DW] = bank_word(w);

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: every completed data phase is compared with the scoreboard
  always @(negedge clk) begin
    if (rst_n && !trdy_n && !irdy_n) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, {cur_req, " unexpected transfer"}, ad_out, 32'h0);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(ad_oe && !devsel_n && ad_out == e, cur_req, ad_out, e);
      end
    end
  end

  task automatic bus_idle();
    @(posedge clk); #1;
    frame_n = 1'b1; irdy_n = 1'b1; ad = '0; cbe_n = 4'hF;
  endtask

  task automatic burst(logic [31:0] addr, int n, logic [3:0] be, int wait_at);
    int idx = int'(addr[5:2]);
    @(posedge clk); #1;
    frame_n = 1'b0; irdy_n = 1'b1; ad = addr; cbe_n = 4'b0110;
    @(posedge clk); #1;
    ad = '0; cbe_n = be;
    @(negedge clk);
    chk(!devsel_n, "R2 claim", {31'b0, devsel_n}, 32'h0);
    chk(trdy_n && !ad_oe, "R4 turnaround", {30'b0, trdy_n, ad_oe}, 32'h2);
    for (int k = 0; k < n; k++) begin
      if (k == wait_at) begin
        @(posedge clk); #1;
        irdy_n = 1'b1; frame_n = 1'b0;
        @(negedge clk);
        chk(!trdy_n && !devsel_n, "R6 wait state", {30'b0, trdy_n, devsel_n}, 32'h0);
      end
      @(posedge clk); #1;
      irdy_n = 1'b0; frame_n = (k == n - 1);
      exp_q.push_back(bank_word(idx) & lane_mask(be));
      idx = (idx + 1) % WORDS;
    end
    bus_idle();
    @(negedge clk);
    chk(devsel_n && trdy_n && !ad_oe, "R9 release",
        {29'b0, devsel_n, trdy_n, ad_oe}, 32'h6);
    chk(exp_q.size() == 0, "R6 phase count", exp_q.size(), 32'h0);
  endtask

  task automatic miss(logic [31:0] addr, logic [3:0] cmd);
    @(posedge clk); #1;
    frame_n = 1'b0; irdy_n = 1'b1; ad = addr; cbe_n = cmd;
    for (int c = 0; c < 3; c++) begin
      @(posedge clk); #1;
      irdy_n = 1'b0; ad = '0; cbe_n = 4'h0;
      @(negedge clk);
      chk(devsel_n && trdy_n && !ad_oe, "R3 no claim",
          {29'b0, devsel_n, trdy_n, ad_oe}, 32'h6);
    end
    bus_idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk(devsel_n && trdy_n && !ad_oe, "R1 in reset", {29'b0, devsel_n, trdy_n, ad_oe}, 32'h6);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(devsel_n && trdy_n && !ad_oe, "R1 after reset", {29'b0, devsel_n, trdy_n, ad_oe}, 32'h6);

    cur_req = "R5 single";
    burst(BASE + 32'h0, 1, 4'h0, -1);
    cur_req = "R6 burst with wait";
    burst(BASE + 32'h10, 4, 4'h0, 2);
    cur_req = "R7 wrap";
    burst(BASE + 32'h38, 4, 4'h0, -1);
    cur_req = "R8 byte lanes";
    burst(BASE + 32'h0C, 2, 4'b1010, -1);
    cur_req = "R8 upper lanes";
    burst(BASE + 32'h24, 1, 4'b0011, 0);

    miss(BASE, 4'b0010);
    miss(BASE + 32'h40, 4'b0110);
    miss(BASE - 32'h4, 4'b0110);
    miss(BASE + 32'h05, 4'b0110);

    cur_req = "R9 back to back";
    burst(BASE + 32'h3C, 3, 4'h0, 1);
    burst(BASE + 32'h20, 2, 4'h0, -1);

    repeat (3) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule